// File: doc/BRIEF.md
# I2C Target Controller with Prioritised Interrupt Flags

This block answers as a target on a two-wire I2C bus and presents a small register window to a local host. Both bus lines are brought into the module clock domain, cleaned of short glitches, and watched for START and STOP conditions. When the address byte, or the two-byte address in extended mode, names the programmed own address, the block acknowledges. It then either takes in data bytes from the controller on the bus or shifts out bytes that the host has placed in a transmit register. The block holds SCL low whenever the controller asks for a byte that the host has not yet supplied.

Four event flags record an address match, a received byte, a freed transmit register and a STOP condition. A mask decides which flags reach the interrupt line. A vector register hands out the most urgent enabled source, clearing it as it is read, so the host drains pending work by reading until it sees zero. A one-shot NACK control lets the host refuse the final byte of a write transfer.

Top module: `i2c_target_ctrl`

## Requirements
- R1: After reset, registers CTRL (address 0), OWN (1), MASK (2), STAT (3), VEC (4) and RX (5) read zero, `irq` is low and neither `scl_oe` nor `sda_oe` is asserted. Read data appears on `reg_rdata` in the cycle after `reg_rd`.
- R2: In 7-bit mode (CTRL bit 1 = 0) an address byte whose bits 7..1 equal OWN bits 6..0 is acknowledged by pulling SDA low during the ninth clock, and STAT bit 0 (address match) is set. Any other address gets no acknowledge and sets no flag other than the STOP flag.
- R3: In 10-bit mode (CTRL bit 1 = 1) a header byte 11110, OWN[9:8], write bit 0, followed by a byte equal to OWN[7:0], is acknowledged twice and sets STAT bit 0. After such a match, a repeated START with the same header and read bit 1 is acknowledged and starts a transmit. A wrong second byte is not acknowledged.
- R4: In a write transfer, every data byte is acknowledged, its value is placed in RX (address 5), and STAT bit 1 (receive ready) is set.
- R5: In a read transfer, the byte written to TX (address 6) is shifted out MSB first. STAT bit 2 (transmit ready) is set when the byte moves into the shifter. If TX is empty at a byte boundary, SCL is held low until the host writes TX.
- R6: Setting CTRL bit 2 makes the next received data byte get a NACK instead of an ACK. The bit then reads back as 0.
- R7: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A STOP ends any transfer and sets STAT bit 3.
- R8: Writing STAT clears each flag whose written bit is 1. Flags written with 0 keep their value.
- R9: MASK bits 3..0 enable the matching STAT bits. `irq` is the OR of the enabled flags, registered one cycle after the flags.
- R10: Reading VEC returns the code of the lowest-numbered enabled pending source (1 address, 2 receive, 3 transmit, 4 stop) and clears that flag. It returns 0 when no enabled flag is pending.
- R11: While CTRL bit 0 (run) is 0, the bus engine stays idle: no acknowledge, no flags, lines released. While run is 1, writes to OWN and to CTRL bit 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sampled level of the SCL wire |
| sda_in | input | 1 | Sampled level of the SDA wire |
| scl_oe | output | 1 | Pull SCL low (clock hold) |
| sda_oe | output | 1 | Pull SDA low (ACK or data 0) |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_addr | input | 3 | Host register address |
| reg_wdata | input | 10 | Host write data |
| reg_rdata | output | 10 | Host read data, valid the cycle after reg_rd |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the host strobes at most one register access per cycle and that both bus lines hold each level far longer than the filter window, so that the only SDA changes seen while SCL is high are intended START or STOP conditions. The bench models an open-drain controller that changes SDA only a quarter bit after SCL falls. It waits on the wired SCL level before each high phase, so a held clock stretches the bit instead of breaking it. Register accesses are made on falling clock edges, one at a time.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int DATA_W  = 10;
  localparam int NUM_SRC = 4;
  localparam int VEC_W   = $clog2(NUM_SRC + 1);

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_OWN  = 3'd1;
  localparam logic [2:0] REG_MASK = 3'd2;
  localparam logic [2:0] REG_STAT = 3'd3;
  localparam logic [2:0] REG_VEC  = 3'd4;
  localparam logic [2:0] REG_RX   = 3'd5;
  localparam logic [2:0] REG_TX   = 3'd6;

  localparam int FL_ADDR = 0;
  localparam int FL_RX   = 1;
  localparam int FL_TX   = 2;
  localparam int FL_STOP = 3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_ADDR2, ST_RX, ST_RX_ACK,
    ST_TX_LOAD, ST_TX, ST_TX_MACK, ST_WAIT
  } eng_state_t;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_out
);
  logic [SYNC_LEN-1:0] sync_q;
  logic [FILT_LEN-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q   <= '1;
      hist_q   <= '1;
      line_out <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_LEN-2:0], line_in};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_LEN-1]};
      if (&hist_q)       line_out <= 1'b1;
      else if (~|hist_q) line_out <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_bus_engine.sv
module i2c_bus_engine
  import i2c_tgt_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              ten_bit,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              nack_once,
  input  logic              scl,
  input  logic              sda,
  input  logic              tx_full,
  input  logic [7:0]        tx_byte,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic              ev_addr,
  output logic              ev_rx,
  output logic              ev_tx,
  output logic              ev_stop,
  output logic [7:0]        rx_byte,
  output logic              nack_used,
  output logic              tx_take
);
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] BYTE_BITS = CNT_W'(8);

  eng_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       shreg;
  logic             scl_q, sda_q;
  logic             rw, hdr10, ten_ok, last_nack;
  logic             scl_rise, scl_fall, start_det, stop_det;

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  assign start_det = scl & scl_q & sda_q & ~sda;
  assign stop_det  = scl & scl_q & ~sda_q & sda;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; cnt <= '0; shreg <= '0;
      scl_q <= 1'b1; sda_q <= 1'b1;
      rw <= 1'b0; hdr10 <= 1'b0; ten_ok <= 1'b0; last_nack <= 1'b0;
      sda_oe <= 1'b0; scl_oe <= 1'b0;
      ev_addr <= 1'b0; ev_rx <= 1'b0; ev_tx <= 1'b0; ev_stop <= 1'b0;
      rx_byte <= '0; nack_used <= 1'b0; tx_take <= 1'b0;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
      ev_addr <= 1'b0; ev_rx <= 1'b0; ev_tx <= 1'b0; ev_stop <= 1'b0;
      nack_used <= 1'b0; tx_take <= 1'b0;
      if (!run) begin
        state <= ST_IDLE; sda_oe <= 1'b0; scl_oe <= 1'b0; ten_ok <= 1'b0;
      end else if (stop_det) begin
        state <= ST_IDLE; sda_oe <= 1'b0; scl_oe <= 1'b0; ten_ok <= 1'b0;
        ev_stop <= 1'b1;
      end else if (start_det) begin
        state <= ST_ADDR; cnt <= '0; sda_oe <= 1'b0; scl_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_ADDR2: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == BYTE_BITS) begin
              state <= ST_WAIT;
              if (state == ST_ADDR2) begin
                if (shreg == own_addr[7:0]) begin
                  sda_oe <= 1'b1; ev_addr <= 1'b1; ten_ok <= 1'b1;
                  hdr10 <= 1'b0; rw <= 1'b0; state <= ST_ADDR_ACK;
                end
              end else if (!ten_bit) begin
                hdr10 <= 1'b0;
                rw    <= shreg[0];
                if (shreg[7:1] == own_addr[6:0]) begin
                  sda_oe <= 1'b1; ev_addr <= 1'b1; state <= ST_ADDR_ACK;
                end
              end else if (shreg[7:3] == 5'b11110 && shreg[2:1] == own_addr[9:8]) begin
                rw <= shreg[0];
                if (!shreg[0]) begin
                  hdr10 <= 1'b1; ten_ok <= 1'b0; sda_oe <= 1'b1;
                  state <= ST_ADDR_ACK;
                end else if (ten_ok) begin
                  hdr10 <= 1'b0; sda_oe <= 1'b1; ev_addr <= 1'b1;
                  state <= ST_ADDR_ACK;
                end
              end else begin
                ten_ok <= 1'b0;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              if (hdr10)   state <= ST_ADDR2;
              else if (rw) state <= ST_TX_LOAD;
              else         state <= ST_RX;
            end
          end
          ST_RX: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == BYTE_BITS) begin
              rx_byte <= shreg;
              ev_rx   <= 1'b1;
              state   <= ST_RX_ACK;
              if (nack_once) begin
                nack_used <= 1'b1; last_nack <= 1'b1; sda_oe <= 1'b0;
              end else begin
                last_nack <= 1'b0; sda_oe <= 1'b1;
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= last_nack ? ST_WAIT : ST_RX;
            end
          end
          ST_TX_LOAD: begin
            if (tx_full) begin
              shreg   <= tx_byte;
              tx_take <= 1'b1;
              ev_tx   <= 1'b1;
              sda_oe  <= ~tx_byte[7];
              scl_oe  <= 1'b0;
              cnt     <= CNT_W'(1);
              state   <= ST_TX;
            end else begin
              scl_oe <= 1'b1;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == BYTE_BITS) begin
                sda_oe <= 1'b0;
                state  <= ST_TX_MACK;
              end else begin
                sda_oe <= ~shreg[6];
                shreg  <= {shreg[6:0], 1'b0};
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_TX_MACK: begin
            if (scl_rise && sda) state <= ST_WAIT;
            else if (scl_fall)   state <= ST_TX_LOAD;
          end
          default: ;
        endcase
      end
    end
  end

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!sda_oe && !scl_oe));
  // R7
  start_release_chk: assert property (@(posedge clk) disable iff (rst)
    (run && start_det) |=> !sda_oe);
  // R5
  stretch_sda_chk: assert property (@(posedge clk) disable iff (rst)
    scl_oe |-> !sda_oe);
endmodule

// File: rtl/i2c_host_regs.sv
module i2c_host_regs
  import i2c_tgt_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  input  logic              ev_addr,
  input  logic              ev_rx,
  input  logic              ev_tx,
  input  logic              ev_stop,
  input  logic [7:0]        rx_byte,
  input  logic              nack_used,
  input  logic              tx_take,
  output logic              run,
  output logic              ten_bit,
  output logic [ADDR_W-1:0] own_addr,
  output logic              nack_once,
  output logic              tx_full,
  output logic [7:0]        tx_byte
);
  logic [NUM_SRC-1:0] flags, imask, set_v, clr_v, pend;
  logic [VEC_W-1:0]   vec_code;
  logic [7:0]         rx_q;
  logic               wr_ctrl, wr_stat, rd_vec;

  assign wr_ctrl = reg_wr && reg_addr == REG_CTRL;
  assign wr_stat = reg_wr && reg_addr == REG_STAT;
  assign rd_vec  = reg_rd && reg_addr == REG_VEC;
  assign pend    = flags & imask;

  always_comb begin
    set_v          = '0;
    set_v[FL_ADDR] = ev_addr;
    set_v[FL_RX]   = ev_rx;
    set_v[FL_TX]   = ev_tx;
    set_v[FL_STOP] = ev_stop;
  end

  always_comb begin
    vec_code = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (pend[i]) vec_code = VEC_W'(i + 1);
  end

  always_comb begin
    clr_v = '0;
    if (wr_stat) clr_v = reg_wdata[NUM_SRC-1:0];
    if (rd_vec && vec_code != '0) clr_v[vec_code - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0; imask <= '0; rx_q <= '0; irq <= 1'b0;
      run <= 1'b0; ten_bit <= 1'b0; own_addr <= '0; nack_once <= 1'b0;
      tx_full <= 1'b0; tx_byte <= '0; reg_rdata <= '0;
    end else begin
      flags <= (flags & ~clr_v) | set_v;
      irq   <= |pend;
      if (ev_rx) rx_q <= rx_byte;
      if (wr_ctrl) begin
        run       <= reg_wdata[0];
        nack_once <= reg_wdata[2];
        if (!run) ten_bit <= reg_wdata[1];
      end else if (nack_used) begin
        nack_once <= 1'b0;
      end
      if (reg_wr && reg_addr == REG_OWN && !run) own_addr <= reg_wdata[ADDR_W-1:0];
      if (reg_wr && reg_addr == REG_MASK) imask <= reg_wdata[NUM_SRC-1:0];
      if (reg_wr && reg_addr == REG_TX) begin
        tx_byte <= reg_wdata[7:0];
        tx_full <= 1'b1;
      end else if (tx_take) begin
        tx_full <= 1'b0;
      end
      if (reg_rd) begin
        unique case (reg_addr)
          REG_CTRL: reg_rdata <= DATA_W'({nack_once, ten_bit, run});
          REG_OWN:  reg_rdata <= DATA_W'(own_addr);
          REG_MASK: reg_rdata <= DATA_W'(imask);
          REG_STAT: reg_rdata <= DATA_W'(flags);
          REG_VEC:  reg_rdata <= DATA_W'(vec_code);
          REG_RX:   reg_rdata <= DATA_W'(rx_q);
          REG_TX:   reg_rdata <= DATA_W'({tx_full, tx_byte});
          default:  reg_rdata <= '0;
        endcase
      end
    end
  end

  // R8
  w1c_rx_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && reg_wdata[FL_RX] && !ev_rx) |=> !flags[FL_RX]);
  // R9
  mask_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (imask == '0 && $stable(imask)) |=> !irq);
  // R6
  nack_once_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (nack_used && !wr_ctrl) |=> !nack_once);
  // R10
  vec_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_vec && pend == '0) |=> reg_rdata == '0);
endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines, clean_lines;
  logic run, ten_bit, nack_once, tx_full, nack_used, tx_take;
  logic ev_addr, ev_rx, ev_tx, ev_stop;
  logic [ADDR_W-1:0] own_addr;
  logic [7:0] tx_byte, rx_byte;

  assign raw_lines = {scl_in, sda_in};

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    i2c_line_filter #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst(rst), .line_in(raw_lines[g]), .line_out(clean_lines[g])
    );
  end

  i2c_bus_engine #(.ADDR_W(ADDR_W)) u_engine (
    .clk(clk), .rst(rst), .run(run), .ten_bit(ten_bit), .own_addr(own_addr),
    .nack_once(nack_once), .scl(clean_lines[1]), .sda(clean_lines[0]),
    .tx_full(tx_full), .tx_byte(tx_byte), .sda_oe(sda_oe), .scl_oe(scl_oe),
    .ev_addr(ev_addr), .ev_rx(ev_rx), .ev_tx(ev_tx), .ev_stop(ev_stop),
    .rx_byte(rx_byte), .nack_used(nack_used), .tx_take(tx_take)
  );

  i2c_host_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .ev_addr(ev_addr), .ev_rx(ev_rx), .ev_tx(ev_tx), .ev_stop(ev_stop),
    .rx_byte(rx_byte), .nack_used(nack_used), .tx_take(tx_take),
    .run(run), .ten_bit(ten_bit), .own_addr(own_addr), .nack_once(nack_once),
    .tx_full(tx_full), .tx_byte(tx_byte)
  );
endmodule

// File: tb/i2c_target_ctrl_bench.sv
module i2c_target_ctrl_bench;
  localparam int Q = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe, irq;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [9:0] reg_wdata = '0;
  logic [9:0] reg_rdata;
  logic scl_line, sda_line;
  logic saw_stretch = 1'b0;
  logic done = 1'b0;
  int total = 0, bad = 0;

  string      exp_req[$];
  logic [9:0] exp_val[$];
  logic [9:0] act_val[$];

  always #5 clk = ~clk;

  assign scl_line = m_scl & ~scl_oe;
  assign sda_line = m_sda & ~sda_oe;

  i2c_target_ctrl u_i2c_target_ctrl (
    .clk(clk), .rst(rst), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always @(posedge clk) if (scl_oe) saw_stretch <= 1'b1;

  // scoreboard monitor
  always @(negedge clk) begin : monitor
    string      r;
    logic [9:0] e, a;
    if (act_val.size() > 0 && exp_val.size() > 0) begin
      r = exp_req.pop_front();
      e = exp_val.pop_front();
      a = act_val.pop_front();
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", r, a, e);
      end
    end
  end

  task automatic chk(input string r, input logic [9:0] act, input logic [9:0] exp);
    exp_req.push_back(r);
    exp_val.push_back(exp);
    act_val.push_back(act);
    @(negedge clk);
  endtask

  task automatic hq();
    repeat (Q) @(posedge clk);
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [9:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [9:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic rd_chk(input string r, input logic [2:0] a, input logic [9:0] exp);
    logic [9:0] d;
    reg_read(a, d);
    chk(r, d, exp);
  endtask

  task automatic scl_high();
    m_scl = 1'b1;
    @(posedge clk);
    while (!scl_line) @(posedge clk);
  endtask

  task automatic m_start();
    m_sda = 1'b1; hq(); scl_high(); hq(); m_sda = 1'b0; hq(); m_scl = 1'b0; hq();
  endtask

  task automatic m_stop();
    m_sda = 1'b0; hq(); scl_high(); hq(); m_sda = 1'b1; hq();
  endtask

  task automatic m_write(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hq(); scl_high(); hq(); m_scl = 1'b0; hq();
    end
    m_sda = 1'b1; hq(); scl_high(); hq(); ack = sda_line; m_scl = 1'b0; hq();
  endtask

  task automatic m_read(input logic nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hq(); scl_high(); hq(); b = {b[6:0], sda_line}; m_scl = 1'b0;
    end
    hq(); m_sda = nack; hq(); scl_high(); hq(); m_scl = 1'b0; hq(); m_sda = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    logic ack;
    logic [7:0] b;
    repeat (4) @(posedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd_chk("R1 ctrl", 3'd0, 10'h0);
    rd_chk("R1 own", 3'd1, 10'h0);
    rd_chk("R1 mask", 3'd2, 10'h0);
    rd_chk("R1 stat", 3'd3, 10'h0);
    rd_chk("R1 vec", 3'd4, 10'h0);
    rd_chk("R1 rx", 3'd5, 10'h0);
    chk("R1 lines", {8'h0, scl_oe, sda_oe}, 10'h0);
    chk("R1 irq", {9'h0, irq}, 10'h0);

    // R11 engine idle while run is 0
    reg_write(3'd1, 10'h048);
    reg_write(3'd2, 10'hF);
    m_start(); m_write(8'h90, ack); m_stop();
    chk("R11 no ack when stopped", {9'h0, ack}, 10'h1);
    rd_chk("R11 no flags when stopped", 3'd3, 10'h0);

    // R11 own address locked while running
    reg_write(3'd0, 10'h1);
    reg_write(3'd1, 10'h022);
    rd_chk("R11 own locked", 3'd1, 10'h048);

    // R2 R4 R7 seven-bit write
    m_start(); m_write(8'h90, ack);
    chk("R2 match ack", {9'h0, ack}, 10'h0);
    m_write(8'hA5, ack);
    chk("R4 data ack", {9'h0, ack}, 10'h0);
    m_write(8'h3C, ack);
    chk("R4 data ack 2", {9'h0, ack}, 10'h0);
    m_stop();
    repeat (10) @(negedge clk);
    chk("R9 irq on", {9'h0, irq}, 10'h1);
    rd_chk("R7 stat after write", 3'd3, 10'h00B);
    rd_chk("R4 rx data", 3'd5, 10'h03C);
    // R10 drain
    rd_chk("R10 vec addr", 3'd4, 10'd1);
    rd_chk("R10 vec rx", 3'd4, 10'd2);
    rd_chk("R10 vec stop", 3'd4, 10'd4);
    rd_chk("R10 vec empty", 3'd4, 10'd0);
    rd_chk("R10 stat drained", 3'd3, 10'h0);

    // R2 mismatch
    m_start(); m_write(8'h92, ack); m_stop();
    chk("R2 mismatch nack", {9'h0, ack}, 10'h1);
    rd_chk("R7 stop only", 3'd3, 10'h008);
    reg_write(3'd3, 10'h008);
    rd_chk("R8 w1c", 3'd3, 10'h0);

    // R6 one-shot nack
    m_start(); m_write(8'h90, ack);
    reg_write(3'd0, 10'h5);
    m_write(8'h77, ack);
    chk("R6 nack sent", {9'h0, ack}, 10'h1);
    rd_chk("R6 bit cleared", 3'd0, 10'h1);
    m_stop();
    rd_chk("R4 rx nacked byte", 3'd5, 10'h077);
    reg_write(3'd3, 10'h002);
    rd_chk("R8 partial w1c", 3'd3, 10'h009);
    reg_write(3'd3, 10'h00F);

    // R9 R10 masking
    reg_write(3'd2, 10'h8);
    m_start(); m_write(8'h90, ack); m_write(8'h01, ack); m_stop();
    repeat (4) @(negedge clk);
    chk("R9 irq stop enabled", {9'h0, irq}, 10'h1);
    reg_write(3'd2, 10'h0);
    repeat (3) @(negedge clk);
    chk("R9 irq masked", {9'h0, irq}, 10'h0);
    rd_chk("R10 vec masked", 3'd4, 10'd0);
    reg_write(3'd2, 10'h2);
    rd_chk("R10 vec rx only", 3'd4, 10'd2);
    rd_chk("R10 vec rest masked", 3'd4, 10'd0);
    rd_chk("R8 flags kept", 3'd3, 10'h009);
    reg_write(3'd3, 10'h00F);
    reg_write(3'd2, 10'hF);

    // R5 read with stall
    reg_write(3'd6, 10'h0C3);
    m_start(); m_write(8'h91, ack);
    chk("R2 read ack", {9'h0, ack}, 10'h0);
    m_read(1'b0, b);
    chk("R5 first byte", {2'b0, b}, 10'h0C3);
    rd_chk("R5 tx flag", 3'd3, 10'h005);
    saw_stretch = 1'b0;
    fork
      m_read(1'b1, b);
      begin repeat (400) @(posedge clk); reg_write(3'd6, 10'h05A); end
    join
    chk("R5 stall byte", {2'b0, b}, 10'h05A);
    chk("R5 scl held", {9'h0, saw_stretch}, 10'h1);
    m_stop();
    reg_write(3'd3, 10'h00F);

    // R3 ten-bit
    reg_write(3'd0, 10'h0);
    reg_write(3'd0, 10'h2);
    reg_write(3'd1, 10'h2B3);
    reg_write(3'd0, 10'h3);
    rd_chk("R3 ctrl", 3'd0, 10'h3);
    m_start(); m_write(8'hF4, ack);
    chk("R3 header ack", {9'h0, ack}, 10'h0);
    m_write(8'hB3, ack);
    chk("R3 low byte ack", {9'h0, ack}, 10'h0);
    m_write(8'h6E, ack);
    chk("R3 data ack", {9'h0, ack}, 10'h0);
    reg_write(3'd6, 10'h081);
    m_start(); m_write(8'hF5, ack);
    chk("R3 read header ack", {9'h0, ack}, 10'h0);
    m_read(1'b1, b);
    chk("R3 read byte", {2'b0, b}, 10'h081);
    m_stop();
    rd_chk("R3 rx", 3'd5, 10'h06E);
    rd_chk("R3 stat", 3'd3, 10'h00F);
    m_start(); m_write(8'hF4, ack); m_write(8'hB4, ack); m_stop();
    chk("R3 wrong low byte", {9'h0, ack}, 10'h1);

    repeat (5) @(negedge clk);
    while (act_val.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule